// File: doc/BRIEF.md
# Partition Freeze State Filter

This block keeps a freeze state for every isolation partition of a host bridge and applies it to traffic that has already been tagged with a partition number. Each partition has two freeze flags. The first gates processor-initiated loads and stores going out to devices. The second gates device-initiated DMA and interrupt messages coming in. Address decoding and requester lookup happen upstream, so every request reaches the block carrying its partition number.

An error-detect source raises a freeze request with a partition number and a cause code. That request sets both flags of the partition together. Software clears each flag separately through a small register port, which also reads the flags back. Once the flags are set, a store to the partition is dropped and a load completes with every data bit set to one, at the same latency as a normal load. DMA requests and interrupt messages from the partition are discarded. A capture register holds the partition and cause of the first freeze event until software clears it.

Top module: `part_freeze_filter`

## Requirements
- R1: After reset both flags of every partition are clear, the capture register is empty (`err_valid`=0) and no load response or register read response is pending.
- R2: A freeze request (`frz_valid`) sets both flags of `frz_part` at the next clock edge. From the following cycle, a register read of that partition returns 2'b11.
- R3: Register op 1 clears only the outbound (MMIO) flag of `reg_part`, and op 2 clears only the inbound (DMA) flag. The other flag of the partition keeps its value.
- R4: An outbound store or load is forwarded in the same cycle (`mmio_fwd_valid`, with address, write flag and data unchanged) when the partition's MMIO flag is clear, and is dropped when the flag is set.
- R5: Every outbound load gets `mmio_resp_valid` exactly one cycle after it is issued. The data is `tgt_rdata` of that cycle when the partition was not frozen, and all ones when it was.
- R6: An inbound DMA request is forwarded in the same cycle when the partition's DMA flag is clear, and is dropped when the flag is set.
- R7: An interrupt message is forwarded with its vector when the partition's DMA flag is clear, and is suppressed when the flag is set.
- R8: When a freeze request and a clear op for the same partition arrive in the same cycle, the freeze wins and both flags end up set. A clear for a different partition in that cycle still takes effect.
- R9: The first freeze request while the capture register is empty latches its partition and 4-bit cause and sets `err_valid`. Later freeze requests leave the captured values unchanged.
- R10: Register op 3 empties the capture register. If a freeze request arrives in the same cycle, that request is captured instead.
- R11: Gating depends only on the addressed partition's own flags. The lowest and highest partition numbers behave like any other.
- R12: Register op 0 returns `reg_rdata` one cycle later with `reg_rvalid`=1, where bit 0 is the MMIO flag and bit 1 is the DMA flag, as they stood in the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmio_valid | input | 1 | Outbound request valid |
| mmio_write | input | 1 | Outbound request is a store |
| mmio_part | input | 8 | Outbound request partition |
| mmio_addr | input | 48 | Outbound request address |
| mmio_wdata | input | 32 | Outbound store data |
| mmio_fwd_valid | output | 1 | Outbound request forwarded |
| mmio_fwd_write | output | 1 | Forwarded store flag |
| mmio_fwd_addr | output | 48 | Forwarded address |
| mmio_fwd_wdata | output | 32 | Forwarded store data |
| tgt_rdata | input | 32 | Target load data, one cycle after the forwarded load |
| mmio_resp_valid | output | 1 | Load response valid |
| mmio_resp_data | output | 32 | Load response data |
| dma_valid | input | 1 | Inbound DMA request valid |
| dma_write | input | 1 | Inbound DMA is a write |
| dma_part | input | 8 | DMA partition |
| dma_addr | input | 48 | DMA address |
| dma_wdata | input | 32 | DMA write data |
| dma_fwd_valid | output | 1 | DMA request forwarded |
| dma_fwd_write | output | 1 | Forwarded DMA write flag |
| dma_fwd_addr | output | 48 | Forwarded DMA address |
| dma_fwd_wdata | output | 32 | Forwarded DMA data |
| msi_valid | input | 1 | Interrupt message valid |
| msi_part | input | 8 | Interrupt message partition |
| msi_vector | input | 11 | Interrupt vector |
| msi_fwd_valid | output | 1 | Interrupt message forwarded |
| msi_fwd_vector | output | 11 | Forwarded vector |
| frz_valid | input | 1 | Freeze request |
| frz_part | input | 8 | Partition to freeze |
| frz_cause | input | 4 | Cause code of the freeze |
| reg_valid | input | 1 | Register op valid |
| reg_op | input | 2 | 0 read, 1 clear MMIO flag, 2 clear DMA flag, 3 clear capture |
| reg_part | input | 8 | Partition addressed by the op |
| reg_rvalid | output | 1 | Read response valid |
| reg_rdata | output | 2 | Read flags: bit 0 MMIO, bit 1 DMA |
| err_valid | output | 1 | Capture register holds an event |
| err_part | output | 8 | Captured partition |
| err_cause | output | 4 | Captured cause |

## Verification
Loads, stores, DMA and interrupt messages are sent to a partition while it is clear, fully frozen, and then half-cleared in each direction. This shows which flag gates which path. Partition 0 and partition 255 are checked next to a neighbouring partition, which would expose an indexing slip. Freeze requests are issued together with a clear for the same partition and together with a clear for a different one, which separates set-wins priority from a clear that is simply lost. A second freeze event and a freeze that coincides with a capture clear show whether the capture keeps the first event and re-arms in the cycle it is cleared.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_CLR_MMIO = 2'd1,
    OP_CLR_DMA  = 2'd2,
    OP_CLR_ERR  = 2'd3
  } pff_op_e;

  localparam int unsigned RD_BIT_MMIO = 0;
  localparam int unsigned RD_BIT_DMA  = 1;
endpackage

// File: rtl/pff_state_table.sv
module pff_state_table #(
  parameter int unsigned PW = 8,
  localparam int unsigned NPART = 1 << PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [PW-1:0]    set_part,
  input  logic             clr_mmio,
  input  logic             clr_dma,
  input  logic [PW-1:0]    clr_part,
  output logic [NPART-1:0] mmio_frz,
  output logic [NPART-1:0] dma_frz
);
  for (genvar g = 0; g < NPART; g++) begin : g_ent
    localparam logic [PW-1:0] IDX = PW'(g);
    logic set_hit, clr_m_hit, clr_d_hit;
    logic m_en, d_en, m_d, d_d, m_q, d_q;

    always_comb begin
      set_hit   = set_valid && (set_part == IDX);
      clr_m_hit = clr_mmio && (clr_part == IDX);
      clr_d_hit = clr_dma && (clr_part == IDX);
      m_en      = set_hit || clr_m_hit;
      d_en      = set_hit || clr_d_hit;
      // a set in the same cycle overrides a clear
      m_d       = set_hit;
      d_d       = set_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        if (m_en) m_q <= m_d;
        if (d_en) d_q <= d_d;
      end
    end

    assign mmio_frz[g] = m_q;
    assign dma_frz[g]  = d_q;
  end
endmodule

// File: rtl/pff_err_capture.sv
module pff_err_capture #(
  parameter int unsigned PW = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [PW-1:0] evt_part,
  input  logic [CW-1:0] evt_cause,
  input  logic          clr,
  output logic          cap_valid,
  output logic [PW-1:0] cap_part,
  output logic [CW-1:0] cap_cause
);
  logic          vld_q, vld_d, load_en, vld_en;
  logic [PW-1:0] part_q;
  logic [CW-1:0] cause_q;

  always_comb begin
    // empty, or being emptied this cycle: the event is the new first one
    load_en = evt_valid && (!vld_q || clr);
    vld_en  = load_en || clr;
    vld_d   = load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      part_q  <= '0;
      cause_q <= '0;
    end else begin
      if (vld_en) vld_q <= vld_d;
      if (load_en) begin
        part_q  <= evt_part;
        cause_q <= evt_cause;
      end
    end
  end

  assign cap_valid = vld_q;
  assign cap_part  = part_q;
  assign cap_cause = cause_q;
endmodule

// File: rtl/pff_mmio_gate.sv
module pff_mmio_gate #(
  parameter int unsigned PW = 8,
  parameter int unsigned AW = 48,
  parameter int unsigned DW = 32,
  localparam int unsigned NPART = 1 << PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPART-1:0] frz,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [PW-1:0]    req_part,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             fwd_valid,
  output logic             fwd_write,
  output logic [AW-1:0]    fwd_addr,
  output logic [DW-1:0]    fwd_wdata,
  input  logic [DW-1:0]    tgt_rdata,
  output logic             resp_valid,
  output logic [DW-1:0]    resp_data
);
  logic hit_frz, load_hit;
  logic rsp_v_q, rsp_v_d, rsp_sq_q, rsp_sq_d;

  always_comb begin
    hit_frz   = frz[req_part];
    load_hit  = req_valid && !req_write;
    fwd_valid = req_valid && !hit_frz;
    fwd_write = req_write;
    fwd_addr  = req_addr;
    fwd_wdata = req_wdata;
    rsp_v_d   = load_hit;
    rsp_sq_d  = load_hit ? hit_frz : rsp_sq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q  <= 1'b0;
      rsp_sq_q <= 1'b0;
    end else begin
      rsp_v_q  <= rsp_v_d;
      rsp_sq_q <= rsp_sq_d;
    end
  end

  assign resp_valid = rsp_v_q;
  assign resp_data  = rsp_sq_q ? {DW{1'b1}} : tgt_rdata;
endmodule

// File: rtl/pff_in_gate.sv
module pff_in_gate #(
  parameter int unsigned PW = 8,
  parameter int unsigned PLW = 32,
  localparam int unsigned NPART = 1 << PW
) (
  input  logic [NPART-1:0] frz,
  input  logic             in_valid,
  input  logic [PW-1:0]    in_part,
  input  logic [PLW-1:0]   in_payload,
  output logic             out_valid,
  output logic [PLW-1:0]   out_payload
);
  always_comb begin
    out_valid   = in_valid && !frz[in_part];
    out_payload = in_payload;
  end
endmodule

// File: rtl/part_freeze_filter.sv
module part_freeze_filter
  import pff_pkg::*;
#(
  parameter int unsigned PW = 8,
  parameter int unsigned AW = 48,
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 11,
  parameter int unsigned CW = 4,
  localparam int unsigned NPART = 1 << PW,
  localparam int unsigned DMA_PL = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mmio_valid,
  input  logic          mmio_write,
  input  logic [PW-1:0] mmio_part,
  input  logic [AW-1:0] mmio_addr,
  input  logic [DW-1:0] mmio_wdata,
  output logic          mmio_fwd_valid,
  output logic          mmio_fwd_write,
  output logic [AW-1:0] mmio_fwd_addr,
  output logic [DW-1:0] mmio_fwd_wdata,
  input  logic [DW-1:0] tgt_rdata,
  output logic          mmio_resp_valid,
  output logic [DW-1:0] mmio_resp_data,
  input  logic          dma_valid,
  input  logic          dma_write,
  input  logic [PW-1:0] dma_part,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic          dma_fwd_valid,
  output logic          dma_fwd_write,
  output logic [AW-1:0] dma_fwd_addr,
  output logic [DW-1:0] dma_fwd_wdata,
  input  logic          msi_valid,
  input  logic [PW-1:0] msi_part,
  input  logic [VW-1:0] msi_vector,
  output logic          msi_fwd_valid,
  output logic [VW-1:0] msi_fwd_vector,
  input  logic          frz_valid,
  input  logic [PW-1:0] frz_part,
  input  logic [CW-1:0] frz_cause,
  input  logic          reg_valid,
  input  logic [1:0]    reg_op,
  input  logic [PW-1:0] reg_part,
  output logic          reg_rvalid,
  output logic [1:0]    reg_rdata,
  output logic          err_valid,
  output logic [PW-1:0] err_part,
  output logic [CW-1:0] err_cause
);
  logic [NPART-1:0] mmio_frz_v, dma_frz_v;
  logic clr_m, clr_d, clr_e, rd_en;
  logic rv_q, rv_d;
  logic [1:0] rd_q, rd_d;
  logic [DMA_PL-1:0] dma_pl_in, dma_pl_out;

  always_comb begin
    clr_m = reg_valid && (reg_op == OP_CLR_MMIO);
    clr_d = reg_valid && (reg_op == OP_CLR_DMA);
    clr_e = reg_valid && (reg_op == OP_CLR_ERR);
    rd_en = reg_valid && (reg_op == OP_READ);
  end

  pff_state_table #(.PW(PW)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .set_valid(frz_valid), .set_part(frz_part),
    .clr_mmio(clr_m), .clr_dma(clr_d), .clr_part(reg_part),
    .mmio_frz(mmio_frz_v), .dma_frz(dma_frz_v)
  );

  pff_err_capture #(.PW(PW), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(frz_valid), .evt_part(frz_part), .evt_cause(frz_cause),
    .clr(clr_e),
    .cap_valid(err_valid), .cap_part(err_part), .cap_cause(err_cause)
  );

  pff_mmio_gate #(.PW(PW), .AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .frz(mmio_frz_v),
    .req_valid(mmio_valid), .req_write(mmio_write), .req_part(mmio_part),
    .req_addr(mmio_addr), .req_wdata(mmio_wdata),
    .fwd_valid(mmio_fwd_valid), .fwd_write(mmio_fwd_write),
    .fwd_addr(mmio_fwd_addr), .fwd_wdata(mmio_fwd_wdata),
    .tgt_rdata(tgt_rdata),
    .resp_valid(mmio_resp_valid), .resp_data(mmio_resp_data)
  );

  assign dma_pl_in = {dma_write, dma_addr, dma_wdata};
  assign {dma_fwd_write, dma_fwd_addr, dma_fwd_wdata} = dma_pl_out;

  pff_in_gate #(.PW(PW), .PLW(DMA_PL)) u_dma (
    .frz(dma_frz_v), .in_valid(dma_valid), .in_part(dma_part),
    .in_payload(dma_pl_in), .out_valid(dma_fwd_valid), .out_payload(dma_pl_out)
  );

  pff_in_gate #(.PW(PW), .PLW(VW)) u_msi (
    .frz(dma_frz_v), .in_valid(msi_valid), .in_part(msi_part),
    .in_payload(msi_vector), .out_valid(msi_fwd_valid), .out_payload(msi_fwd_vector)
  );

  always_comb begin
    rv_d = rd_en;
    rd_d = rd_q;
    if (rd_en) begin
      rd_d[RD_BIT_MMIO] = mmio_frz_v[reg_part];
      rd_d[RD_BIT_DMA]  = dma_frz_v[reg_part];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= 2'b00;
    end else begin
      rv_q <= rv_d;
      rd_q <= rd_d;
    end
  end

  assign reg_rvalid = rv_q;
  assign reg_rdata  = rd_q;
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 4,
  localparam int unsigned NPART = 1 << PW
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPART-1:0] mmio_frz,
  input logic [NPART-1:0] dma_frz,
  input logic             mmio_valid,
  input logic             mmio_write,
  input logic [PW-1:0]    mmio_part,
  input logic             mmio_fwd_valid,
  input logic             mmio_resp_valid,
  input logic [DW-1:0]    mmio_resp_data,
  input logic             dma_valid,
  input logic [PW-1:0]    dma_part,
  input logic             dma_fwd_valid,
  input logic             msi_valid,
  input logic [PW-1:0]    msi_part,
  input logic             msi_fwd_valid,
  input logic             frz_valid,
  input logic [PW-1:0]    frz_part,
  input logic             reg_valid,
  input logic [1:0]       reg_op,
  input logic [PW-1:0]    reg_part,
  input logic             reg_rvalid,
  input logic             err_valid,
  input logic [PW-1:0]    err_part,
  input logic [CW-1:0]    err_cause
);
  a_r2_pair_set: assert property (@(posedge clk) disable iff (!rst_n)
    frz_valid |=> (mmio_frz[$past(frz_part)] && dma_frz[$past(frz_part)]));

  a_r3_mmio_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_op == 2'd1 && !frz_valid) |=>
      (!mmio_frz[$past(reg_part)] && dma_frz[$past(reg_part)] == $past(dma_frz[reg_part])));

  a_r4_drop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && mmio_frz[mmio_part]) |-> !mmio_fwd_valid);

  a_r5_resp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && !mmio_write) |=> mmio_resp_valid);

  a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && !mmio_write && mmio_frz[mmio_part]) |=> (mmio_resp_data == {DW{1'b1}}));

  a_r6_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_frz[dma_part]) |-> !dma_fwd_valid);

  a_r7_msi_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && dma_frz[msi_part]) |-> !msi_fwd_valid);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_valid && reg_valid && reg_op == 2'd1 && reg_part == frz_part) |=> mmio_frz[$past(frz_part)]);

  a_r9_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !(reg_valid && reg_op == 2'd3)) |=>
      (err_valid && $stable(err_part) && $stable(err_cause)));

  a_r10_clear_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_op == 2'd3 && !frz_valid) |=> !err_valid);

  a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_op == 2'd0) |=> reg_rvalid);
endmodule

bind part_freeze_filter pff_checker #(.PW(PW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mmio_frz(mmio_frz_v), .dma_frz(dma_frz_v),
  .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_part(mmio_part),
  .mmio_fwd_valid(mmio_fwd_valid),
  .mmio_resp_valid(mmio_resp_valid), .mmio_resp_data(mmio_resp_data),
  .dma_valid(dma_valid), .dma_part(dma_part), .dma_fwd_valid(dma_fwd_valid),
  .msi_valid(msi_valid), .msi_part(msi_part), .msi_fwd_valid(msi_fwd_valid),
  .frz_valid(frz_valid), .frz_part(frz_part),
  .reg_valid(reg_valid), .reg_op(reg_op), .reg_part(reg_part),
  .reg_rvalid(reg_rvalid),
  .err_valid(err_valid), .err_part(err_part), .err_cause(err_cause)
);

// File: tb/test_part_freeze_filter.sv
module test_part_freeze_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        mmio_valid = 0, mmio_write = 0;
  logic [7:0]  mmio_part = 0;
  logic [47:0] mmio_addr = 0;
  logic [31:0] mmio_wdata = 0, tgt_rdata = 0;
  logic        mmio_fwd_valid, mmio_fwd_write, mmio_resp_valid;
  logic [47:0] mmio_fwd_addr;
  logic [31:0] mmio_fwd_wdata, mmio_resp_data;
  logic        dma_valid = 0, dma_write = 0;
  logic [7:0]  dma_part = 0;
  logic [47:0] dma_addr = 0;
  logic [31:0] dma_wdata = 0;
  logic        dma_fwd_valid, dma_fwd_write;
  logic [47:0] dma_fwd_addr;
  logic [31:0] dma_fwd_wdata;
  logic        msi_valid = 0;
  logic [7:0]  msi_part = 0;
  logic [10:0] msi_vector = 0;
  logic        msi_fwd_valid;
  logic [10:0] msi_fwd_vector;
  logic        frz_valid = 0;
  logic [7:0]  frz_part = 0;
  logic [3:0]  frz_cause = 0;
  logic        reg_valid = 0;
  logic [1:0]  reg_op = 0;
  logic [7:0]  reg_part = 0;
  logic        reg_rvalid, err_valid;
  logic [1:0]  reg_rdata;
  logic [7:0]  err_part;
  logic [3:0]  err_cause;

  part_freeze_filter i_part_freeze_filter (.*);

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for load responses
  always @(negedge clk) begin
    #1;
    if (rst_n && mmio_resp_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected response", 1, 0);
      else check(tag_q.pop_front(), mmio_resp_data, exp_q.pop_front());
    end
  end

  task automatic load(input logic [7:0] p, input bit frozen, input logic [31:0] td, input string req);
    @(negedge clk);
    mmio_valid = 1; mmio_write = 0; mmio_part = p; mmio_addr = {40'h1234, p};
    exp_q.push_back(frozen ? 32'hFFFF_FFFF : td);
    tag_q.push_back(req);
    #1 check({req, " fwd"}, mmio_fwd_valid, !frozen);
    @(negedge clk);
    mmio_valid = 0; tgt_rdata = td;
  endtask

  task automatic store(input logic [7:0] p, input bit exp_fwd, input string req);
    @(negedge clk);
    mmio_valid = 1; mmio_write = 1; mmio_part = p; mmio_wdata = 32'hC0DE_0000 | p;
    #1 check(req, mmio_fwd_valid, exp_fwd);
    if (exp_fwd) check({req, " data"}, mmio_fwd_wdata, 32'hC0DE_0000 | p);
    @(negedge clk) mmio_valid = 0;
  endtask

  task automatic dma(input logic [7:0] p, input bit exp_fwd, input string req);
    @(negedge clk);
    dma_valid = 1; dma_write = 1; dma_part = p; dma_addr = 48'hABC0 + p; dma_wdata = 32'h55;
    #1 check(req, dma_fwd_valid, exp_fwd);
    @(negedge clk) dma_valid = 0;
  endtask

  task automatic msi(input logic [7:0] p, input bit exp_fwd, input string req);
    @(negedge clk);
    msi_valid = 1; msi_part = p; msi_vector = 11'h3A5;
    #1 check(req, msi_fwd_valid, exp_fwd);
    if (exp_fwd) check({req, " vector"}, msi_fwd_vector, 11'h3A5);
    @(negedge clk) msi_valid = 0;
  endtask

  // one cycle with an optional freeze request and an optional register op
  task automatic pulse(input bit fv, input logic [7:0] fp, input logic [3:0] fc,
                       input bit rv, input logic [1:0] op, input logic [7:0] rp);
    @(negedge clk);
    frz_valid = fv; frz_part = fp; frz_cause = fc;
    reg_valid = rv; reg_op = op; reg_part = rp;
    @(negedge clk);
    frz_valid = 0; reg_valid = 0;
  endtask

  task automatic rd(input logic [7:0] p, input logic [1:0] exp, input string req);
    @(negedge clk);
    reg_valid = 1; reg_op = 2'd0; reg_part = p;
    @(negedge clk);
    reg_valid = 0;
    #1;
    check({req, " rvalid"}, reg_rvalid, 1);
    check(req, reg_rdata, exp);
  endtask

  task automatic err_chk(input bit v, input logic [7:0] p, input logic [3:0] c, input string req);
    @(negedge clk);
    #1;
    check({req, " valid"}, err_valid, v);
    if (v) begin
      check({req, " part"}, err_part, p);
      check({req, " cause"}, err_cause, c);
    end
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #1;
    check("R1 no load response", mmio_resp_valid, 0);
    check("R1 no read response", reg_rvalid, 0);
    check("R1 capture empty", err_valid, 0);
    rd(8'd0, 2'b00, "R1 part0 flags");
    rd(8'd255, 2'b00, "R1 part255 flags");
    // R4, R5: unfrozen traffic
    store(8'd5, 1, "R4 store clear part");
    load(8'd5, 0, 32'h1111_2222, "R5 load clear part");
    dma(8'd5, 1, "R6 dma clear part");
    msi(8'd5, 1, "R7 msi clear part");
    // R2, R9: freeze 5
    pulse(1, 8'd5, 4'h3, 0, 2'd0, 8'd0);
    err_chk(1, 8'd5, 4'h3, "R9 first capture");
    rd(8'd5, 2'b11, "R2 pair set");
    store(8'd5, 0, "R4 store dropped");
    load(8'd5, 1, 32'h3333_4444, "R5 load all ones");
    dma(8'd5, 0, "R6 dma dropped");
    msi(8'd5, 0, "R7 msi suppressed");
    store(8'd6, 1, "R11 neighbour store");
    load(8'd6, 0, 32'h5555_6666, "R11 neighbour load");
    // R9: later event does not overwrite
    pulse(1, 8'd200, 4'h9, 0, 2'd0, 8'd0);
    err_chk(1, 8'd5, 4'h3, "R9 keep first");
    rd(8'd200, 2'b11, "R2 second part");
    // R3: independent clears
    pulse(0, 8'd0, 4'h0, 1, 2'd1, 8'd5);
    rd(8'd5, 2'b10, "R3 mmio cleared dma kept");
    store(8'd5, 1, "R3 store passes after mmio clear");
    dma(8'd5, 0, "R3 dma still dropped");
    msi(8'd5, 0, "R7 msi still suppressed");
    pulse(0, 8'd0, 4'h0, 1, 2'd2, 8'd200);
    rd(8'd200, 2'b01, "R3 dma cleared mmio kept");
    dma(8'd200, 1, "R3 dma passes after dma clear");
    store(8'd200, 0, "R3 store still dropped");
    pulse(0, 8'd0, 4'h0, 1, 2'd2, 8'd5);
    rd(8'd5, 2'b00, "R3 both clear");
    msi(8'd5, 1, "R7 msi passes after clear");
    // R8: set wins for same part, other-part clear still applies
    pulse(1, 8'd7, 4'h1, 1, 2'd1, 8'd7);
    rd(8'd7, 2'b11, "R8 set beats clear");
    pulse(1, 8'd9, 4'h2, 1, 2'd1, 8'd200);
    rd(8'd200, 2'b00, "R8 other clear applied");
    rd(8'd9, 2'b11, "R8 set applied");
    // R10: clear capture, then clear with coincident event
    pulse(0, 8'd0, 4'h0, 1, 2'd3, 8'd0);
    err_chk(0, 8'd0, 4'h0, "R10 capture cleared");
    pulse(1, 8'd42, 4'hC, 1, 2'd3, 8'd0);
    err_chk(1, 8'd42, 4'hC, "R10 clear with event");
    // R11: boundary partitions
    pulse(1, 8'd255, 4'h4, 0, 2'd0, 8'd0);
    load(8'd255, 1, 32'h7777_8888, "R11 part255 frozen");
    load(8'd254, 0, 32'h9999_AAAA, "R11 part254 clear");
    load(8'd0, 0, 32'hBBBB_CCCC, "R11 part0 clear");
    dma(8'd255, 0, "R11 dma part255");
    // R5: back-to-back loads with mixed state
    @(negedge clk);
    mmio_valid = 1; mmio_write = 0; mmio_part = 8'd9;
    exp_q.push_back(32'hFFFF_FFFF); tag_q.push_back("R5 b2b frozen");
    @(negedge clk);
    mmio_part = 8'd10;
    exp_q.push_back(32'h0BAD_F00D); tag_q.push_back("R5 b2b clear");
    @(negedge clk);
    mmio_valid = 0; tgt_rdata = 32'h0BAD_F00D;
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule